// File: doc/BRIEF.md
# Mode-Gated MMIO Access Controller

This block sits between a 32-bit CPU bus and the memories and peripheral cores of a small secure device. It splits the address space into ROM, RAM, a reserved hole and a memory-mapped region. In the memory-mapped region it drives one select line per peripheral core, and it multiplexes read data back to the CPU. It also contains a few registers of its own: a system core with identity constants, a one-way mode switch, the application load address and size, and a device authentication key window. It serves a secret-key window as well, in which each word can be read only once.

After reset the block is in loader mode, and trusted firmware can see everything. A non-zero write to the switch register moves the block into application mode. From then on, the secret-key window, the firmware-only RAM and the authentication key are hidden, and the application address and size registers can no longer be written. A hidden read returns zero. A blocked write changes nothing. Either kind of attempt raises a one-cycle violation flag. Only reset brings the block back to loader mode.

Top module: `mmio_gate_ctrl`

## Requirements
- R1: Address bits [31:30] pick the region: 00 asserts `rom_sel_o` and returns `rom_rdata_i`, 01 asserts `ram_sel_o` and returns `ram_rdata_i`, 10 selects nothing and returns zero, and 11 is the memory-mapped region. A select is asserted only while a read or a write is requested. `rdata_o` is zero whenever `bus_re_i` is low.
- R2: In the memory-mapped region the top address byte picks the core. The external select lines and read-data lanes are: 0xC0 is bit 0 (lane 0), 0xC1 is bit 1, 0xC3 is bit 2, 0xC4 is bit 3 and 0xD0, the firmware RAM, is bit 4. Lane i occupies `ext_rdata_i[32i+31:32i]`. Any other top byte, apart from 0xC2 and 0xFF, reads zero and selects nothing.
- R3: Within core 0xFF, word offset 0x00 reads 0x6D746131 ("mta1", first character in the top byte), offset 0x04 reads 0x6D6B6466 ("mkdf"), and offset 0x08 reads the version, which defaults to 1.
- R4: A write of a non-zero value to 0xFF000010 in loader mode sets `app_mode_o` from the next cycle. A zero write does nothing. Once set, the mode stays set until reset.
- R5: In loader mode, 0xFF000020 (application address) and 0xFF000024 (application size) can be written, and reads return the last value written.
- R6: In application mode, writes to the application address, the application size or the switch register leave the stored values unchanged and are flagged as violations.
- R7: In loader mode, the first read of 0xC2000000 + 4k (k from 0 to 7) returns `secret_key_i[32k+31:32k]`. Every later read of that word returns zero.
- R8: In application mode, reads of core 0xC2, of core 0xD0 and of the authentication words return zero, and the firmware RAM select is never asserted.
- R9: `viol_o` is high in the cycle after a blocked access, for that cycle only. It is never high after an access that was allowed.
- R10: Reset clears the mode bit, the read-once flags, the application address and size, and the violation flag.
- R11: In loader mode, 0xFF000040 + 4k (k from 0 to 3) returns `auth_key_i[32k+31:32k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 32 | CPU byte address |
| bus_re_i | input | 1 | Read request |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| rom_rdata_i | input | 32 | Read data from ROM |
| ram_rdata_i | input | 32 | Read data from RAM |
| ext_rdata_i | input | 160 | Read data lanes of the five external cores |
| secret_key_i | input | 256 | Eight secret-key words |
| auth_key_i | input | 128 | Four authentication-key words |
| rom_sel_o | output | 1 | ROM select |
| ram_sel_o | output | 1 | RAM select |
| ext_sel_o | output | 5 | External core selects |
| rdata_o | output | 32 | Read data to CPU |
| viol_o | output | 1 | One-cycle access-violation pulse |
| app_mode_o | output | 1 | High in application mode |

## Verification
The decoder is swept over every value of the top address byte, and both the read data and the full select vector are compared against values worked out from the region and core codes. This sweep separates ROM, RAM, the reserved hole, each core lane and unmapped codes. Every secret-key word is then read twice in a row, which separates a first read from a repeated read. The same protected addresses are then accessed again after the mode switch, to tell a permitted access from a hidden or blocked one. Finally, a reset in the middle of the run shows that the mode and the read-once flags come back cleared. The violation pulse is checked both after each blocked access and in the idle cycle that follows it.

// File: rtl/mgc_pkg.sv
`timescale 1ns/1ps
package mgc_pkg;

  typedef enum logic [1:0] {
    RGN_ROM  = 2'b00,
    RGN_RAM  = 2'b01,
    RGN_RSV  = 2'b10,
    RGN_MMIO = 2'b11
  } region_e;

  localparam int EXT_N     = 5;
  localparam int EXT_FWRAM = 4;
  localparam logic [7:0] EXT_CODE [EXT_N] = '{8'hC0, 8'hC1, 8'hC3, 8'hC4, 8'hD0};

  localparam logic [7:0] CODE_SECRET = 8'hC2;
  localparam logic [7:0] CODE_SYS    = 8'hFF;

  localparam int WORD_W = 22;
  localparam logic [WORD_W-1:0] W_ID0     = 22'd0;
  localparam logic [WORD_W-1:0] W_ID1     = 22'd1;
  localparam logic [WORD_W-1:0] W_VER     = 22'd2;
  localparam logic [WORD_W-1:0] W_SWITCH  = 22'd4;
  localparam logic [WORD_W-1:0] W_APPADDR = 22'd8;
  localparam logic [WORD_W-1:0] W_APPSIZE = 22'd9;
  localparam logic [WORD_W-1:0] W_AUTH0   = 22'd16;

  localparam logic [31:0] ID_WORD0 = 32'h6D746131;
  localparam logic [31:0] ID_WORD1 = 32'h6D6B6466;

  typedef struct packed {
    logic              is_rom;
    logic              is_ram;
    logic              is_secret;
    logic              is_sys;
    logic [EXT_N-1:0]  ext_hit;
    logic [WORD_W-1:0] word;
  } dec_t;

endpackage

// File: rtl/mgc_addr_decode.sv
`timescale 1ns/1ps
module mgc_addr_decode
  import mgc_pkg::*;
(
  input  logic [31:0] addr_i,
  output dec_t        dec_o
);

  region_e rgn;
  logic    in_mmio;
  logic [7:0] code;
  logic [EXT_N-1:0] hit;

  assign rgn     = region_e'(addr_i[31:30]);
  assign in_mmio = (rgn == RGN_MMIO);
  assign code    = addr_i[31:24];

  for (genvar g = 0; g < EXT_N; g++) begin : g_ext
    assign hit[g] = in_mmio && (code == EXT_CODE[g]);
  end

  always_comb begin
    dec_o           = '0;
    dec_o.is_rom    = (rgn == RGN_ROM);
    dec_o.is_ram    = (rgn == RGN_RAM);
    dec_o.is_secret = in_mmio && (code == CODE_SECRET);
    dec_o.is_sys    = in_mmio && (code == CODE_SYS);
    dec_o.ext_hit   = hit;
    dec_o.word      = addr_i[23:2];
  end

endmodule

// File: rtl/mgc_secret_win.sv
`timescale 1ns/1ps
module mgc_secret_win
  import mgc_pkg::*;
#(
  parameter  int KEY_WORDS = 8,
  localparam int IW        = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hit_i,
  input  logic [WORD_W-1:0]       word_i,
  input  logic                    re_i,
  input  logic                    we_i,
  input  logic                    app_mode_i,
  input  logic [KEY_WORDS*32-1:0] key_i,
  output logic [31:0]             rdata_o,
  output logic                    blocked_o
);

  logic [31:0]          key_w [KEY_WORDS];
  logic [KEY_WORDS-1:0] done_q, done_d;
  logic [IW-1:0]        idx;
  logic                 in_range;
  logic                 read_ok;

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    assign key_w[k] = key_i[k*32 +: 32];
  end

  assign idx      = word_i[IW-1:0];
  assign in_range = (word_i[WORD_W-1:IW] == '0) && ({1'b0, idx} < (IW+1)'(KEY_WORDS));
  assign read_ok  = hit_i && re_i && !app_mode_i && in_range;

  // next state and read path
  always_comb begin
    done_d  = done_q;
    rdata_o = '0;
    if (read_ok) begin
      done_d[idx] = 1'b1;
      if (!done_q[idx]) rdata_o = key_w[idx];
    end
  end

  assign blocked_o = hit_i && (re_i || we_i) && app_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      done_q <= '0;
    else if (read_ok) done_q <= done_d;
  end

endmodule

// File: rtl/mgc_sys_regs.sv
`timescale 1ns/1ps
module mgc_sys_regs
  import mgc_pkg::*;
#(
  parameter  int          AUTH_WORDS = 4,
  parameter  logic [31:0] VERSION    = 32'd1,
  localparam int          AIW        = (AUTH_WORDS > 1) ? $clog2(AUTH_WORDS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hit_i,
  input  logic [WORD_W-1:0]        word_i,
  input  logic                     re_i,
  input  logic                     we_i,
  input  logic [31:0]              wdata_i,
  input  logic [AUTH_WORDS*32-1:0] auth_key_i,
  output logic                     app_mode_o,
  output logic [31:0]              rdata_o,
  output logic                     blocked_o
);

  logic [31:0] auth_w [AUTH_WORDS];
  logic        mode_q, mode_d;
  logic [31:0] app_addr_q, app_addr_d;
  logic [31:0] app_size_q, app_size_d;
  logic [WORD_W-1:0] auth_off;
  logic        in_auth;
  logic        wr, rd;

  for (genvar k = 0; k < AUTH_WORDS; k++) begin : g_auth
    assign auth_w[k] = auth_key_i[k*32 +: 32];
  end

  assign auth_off = word_i - W_AUTH0;
  assign in_auth  = (word_i >= W_AUTH0) && (auth_off < WORD_W'(AUTH_WORDS));
  assign wr       = hit_i && we_i;
  assign rd       = hit_i && re_i;

  // next state, read mux and blocking decision
  always_comb begin
    mode_d     = mode_q;
    app_addr_d = app_addr_q;
    app_size_d = app_size_q;
    blocked_o  = 1'b0;
    rdata_o    = '0;
    if (wr) begin
      case (word_i)
        W_SWITCH: begin
          if (mode_q)              blocked_o = 1'b1;
          else if (wdata_i != '0)  mode_d    = 1'b1;
        end
        W_APPADDR: begin
          if (mode_q) blocked_o  = 1'b1;
          else        app_addr_d = wdata_i;
        end
        W_APPSIZE: begin
          if (mode_q) blocked_o  = 1'b1;
          else        app_size_d = wdata_i;
        end
        default: begin
          if (in_auth && mode_q) blocked_o = 1'b1;
        end
      endcase
    end
    if (rd) begin
      case (word_i)
        W_ID0:     rdata_o = ID_WORD0;
        W_ID1:     rdata_o = ID_WORD1;
        W_VER:     rdata_o = VERSION;
        W_APPADDR: rdata_o = app_addr_q;
        W_APPSIZE: rdata_o = app_size_q;
        default: begin
          if (in_auth) begin
            if (mode_q) blocked_o = 1'b1;
            else        rdata_o   = auth_w[auth_off[AIW-1:0]];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      app_addr_q <= '0;
      app_size_q <= '0;
    end else if (wr) begin
      mode_q     <= mode_d;
      app_addr_q <= app_addr_d;
      app_size_q <= app_size_d;
    end
  end

  assign app_mode_o = mode_q;

endmodule

// File: rtl/mmio_gate_ctrl.sv
`timescale 1ns/1ps
module mmio_gate_ctrl
  import mgc_pkg::*;
#(
  parameter int          KEY_WORDS  = 8,
  parameter int          AUTH_WORDS = 4,
  parameter logic [31:0] VERSION    = 32'd1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [31:0]              bus_addr_i,
  input  logic                     bus_re_i,
  input  logic                     bus_we_i,
  input  logic [31:0]              bus_wdata_i,
  input  logic [31:0]              rom_rdata_i,
  input  logic [31:0]              ram_rdata_i,
  input  logic [EXT_N*32-1:0]      ext_rdata_i,
  input  logic [KEY_WORDS*32-1:0]  secret_key_i,
  input  logic [AUTH_WORDS*32-1:0] auth_key_i,
  output logic                     rom_sel_o,
  output logic                     ram_sel_o,
  output logic [EXT_N-1:0]         ext_sel_o,
  output logic [31:0]              rdata_o,
  output logic                     viol_o,
  output logic                     app_mode_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dec_t        dec;
  logic        access;
  logic        app_mode;
  logic [31:0] sec_rdata, sys_rdata;
  logic        sec_blk, sys_blk, fwram_blk;
  logic [EXT_N-1:0] ext_open;
  logic [31:0] ext_w [EXT_N];
  logic        viol_q, viol_d;

  assign access = bus_re_i || bus_we_i;

  mgc_addr_decode u_dec (
    .addr_i (bus_addr_i),
    .dec_o  (dec)
  );

  mgc_secret_win #(.KEY_WORDS(KEY_WORDS)) u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .hit_i      (dec.is_secret),
    .word_i     (dec.word),
    .re_i       (bus_re_i),
    .we_i       (bus_we_i),
    .app_mode_i (app_mode),
    .key_i      (secret_key_i),
    .rdata_o    (sec_rdata),
    .blocked_o  (sec_blk)
  );

  mgc_sys_regs #(.AUTH_WORDS(AUTH_WORDS), .VERSION(VERSION)) u_sys (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .hit_i      (dec.is_sys),
    .word_i     (dec.word),
    .re_i       (bus_re_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .auth_key_i (auth_key_i),
    .app_mode_o (app_mode),
    .rdata_o    (sys_rdata),
    .blocked_o  (sys_blk)
  );

  // external core gating: the firmware RAM closes in application mode
  for (genvar g = 0; g < EXT_N; g++) begin : g_sel
    assign ext_w[g] = ext_rdata_i[g*32 +: 32];
    if (g == EXT_FWRAM) begin : g_gated
      assign ext_open[g] = dec.ext_hit[g] && !app_mode;
    end else begin : g_open
      assign ext_open[g] = dec.ext_hit[g];
    end
    assign ext_sel_o[g] = ext_open[g] && access;
  end

  assign rom_sel_o = dec.is_rom && access;
  assign ram_sel_o = dec.is_ram && access;
  assign fwram_blk = dec.ext_hit[EXT_FWRAM] && access && app_mode;

  always_comb begin
    rdata_o = '0;
    if (bus_re_i) begin
      if (dec.is_rom)    rdata_o = rom_rdata_i;
      if (dec.is_ram)    rdata_o = ram_rdata_i;
      if (dec.is_secret) rdata_o = sec_rdata;
      if (dec.is_sys)    rdata_o = sys_rdata;
      for (int i = 0; i < EXT_N; i++) begin
        if (ext_open[i]) rdata_o = ext_w[i];
      end
    end
  end

  // violation pulse: next state and register
  always_comb viol_d = sec_blk || sys_blk || fwram_blk;

  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) viol_q <= 1'b0;
    else             viol_q <= viol_d;
  end

  assign viol_o     = viol_q;
  assign app_mode_o = app_mode;

endmodule

// File: rtl/mgc_checker.sv
`timescale 1ns/1ps
module mgc_checker #(
  parameter int EXT_W = 5,
  parameter int FW_IX = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      bus_addr_i,
  input logic             bus_re_i,
  input logic             rom_sel_o,
  input logic             ram_sel_o,
  input logic [EXT_W-1:0] ext_sel_o,
  input logic [31:0]      rdata_o,
  input logic             viol_o,
  input logic             app_mode_o
);

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |-> rdata_o == '0);

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_sel_o, ram_sel_o, ext_sel_o}));

  p_mode_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_mode_o |=> app_mode_o);

  p_read_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!app_mode_o && bus_re_i && bus_addr_i[31:24] == 8'hC2)
      |=> (!(bus_re_i && $stable(bus_addr_i)) || rdata_o == '0));

  p_hidden_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (app_mode_o && bus_re_i &&
     (bus_addr_i[31:24] == 8'hC2 || bus_addr_i[31:24] == 8'hD0)) |-> rdata_o == '0);

  p_fwram_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_mode_o |-> !ext_sel_o[FW_IX]);

  p_viol_in_app_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(app_mode_o));

endmodule

bind mmio_gate_ctrl mgc_checker #(.EXT_W(mgc_pkg::EXT_N), .FW_IX(mgc_pkg::EXT_FWRAM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_re_i   (bus_re_i),
  .rom_sel_o  (rom_sel_o),
  .ram_sel_o  (ram_sel_o),
  .ext_sel_o  (ext_sel_o),
  .rdata_o    (rdata_o),
  .viol_o     (viol_o),
  .app_mode_o (app_mode_o)
);

// File: tb/mmio_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module mmio_gate_ctrl_tb_top;

  localparam int KW = 8;
  localparam int AW = 4;
  localparam int EN = 5;
  localparam logic [31:0] ROMD = 32'h1111_0000;
  localparam logic [31:0] RAMD = 32'h2222_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [31:0]   bus_addr, bus_wdata;
  logic          bus_re, bus_we;
  logic [EN*32-1:0] ext_rdata;
  logic [KW*32-1:0] key;
  logic [AW*32-1:0] auth;
  logic          rom_sel, ram_sel, viol, app_mode;
  logic [EN-1:0] ext_sel;
  logic [31:0]   rdata;

  int checks = 0;
  int errors = 0;

  mmio_gate_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_re_i(bus_re),
    .bus_we_i(bus_we), .bus_wdata_i(bus_wdata), .rom_rdata_i(ROMD),
    .ram_rdata_i(RAMD), .ext_rdata_i(ext_rdata), .secret_key_i(key),
    .auth_key_i(auth), .rom_sel_o(rom_sel), .ram_sel_o(ram_sel),
    .ext_sel_o(ext_sel), .rdata_o(rdata), .viol_o(viol), .app_mode_o(app_mode)
  );

  function automatic logic [31:0] ext_val(int i);
    return 32'hA000_0000 | 32'(i);
  endfunction
  function automatic logic [31:0] key_val(int k);
    return 32'h5EC0_0000 | 32'(k * 3 + 1);
  endfunction
  function automatic logic [31:0] auth_val(int k);
    return 32'hA07E_0000 | 32'(k * 7 + 2);
  endfunction

  function automatic logic [31:0] exp_word(logic [7:0] t);
    case (t[7:6])
      2'b00: return ROMD;
      2'b01: return RAMD;
      2'b10: return 32'h0;
      default: case (t)
        8'hC0: return ext_val(0);
        8'hC1: return ext_val(1);
        8'hC3: return ext_val(2);
        8'hC4: return ext_val(3);
        8'hD0: return ext_val(4);
        8'hFF: return 32'h6D74_6131;
        default: return 32'h0;
      endcase
    endcase
  endfunction

  function automatic logic [6:0] exp_sel(logic [7:0] t);
    return {t[7:6] == 2'b00, t[7:6] == 2'b01, t == 8'hD0, t == 8'hC4,
            t == 8'hC3, t == 8'hC1, t == 8'hC0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d,
                    output logic [6:0] s, output logic v);
    bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    #1;
    d = rdata;
    s = {rom_sel, ram_sel, ext_sel};
    @(negedge clk);
    v = viol;
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] w, output logic v);
    bus_addr = a; bus_wdata = w; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk);
    v = viol;
    bus_we = 1'b0;
  endtask

  task automatic idle(output logic v);
    bus_re = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    v = viol;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [6:0]  s;
    logic        v;

    for (int i = 0; i < EN; i++) ext_rdata[i*32 +: 32] = ext_val(i);
    for (int k = 0; k < KW; k++) key[k*32 +: 32] = key_val(k);
    for (int k = 0; k < AW; k++) auth[k*32 +: 32] = auth_val(k);
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_re = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset mode", 32'(app_mode), 32'h0);
    chk("R10 reset viol", 32'(viol), 32'h0);
    chk("R1 idle rdata", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: sweep the whole top byte
    for (int t = 0; t < 256; t++) begin
      if (t != 8'hC2) begin
        rd({8'(t), 24'h0}, d, s, v);
        chk($sformatf("R1 R2 data top=%h", t), d, exp_word(8'(t)));
        chk($sformatf("R2 sel top=%h", t), 32'(s), 32'(exp_sel(8'(t))));
        chk($sformatf("R9 no viol top=%h", t), 32'(v), 32'h0);
      end
    end

    // R3 identity and version
    rd(32'hFF00_0004, d, s, v); chk("R3 id1", d, 32'h6D6B_6466);
    rd(32'hFF00_0008, d, s, v); chk("R3 version", d, 32'h1);

    // R11 authentication key in loader mode
    for (int k = 0; k < AW; k++) begin
      rd(32'hFF00_0040 + 32'(4 * k), d, s, v);
      chk($sformatf("R11 auth %0d", k), d, auth_val(k));
    end

    // R7 read-once secret words
    for (int k = 0; k < KW; k++) begin
      rd(32'hC200_0000 + 32'(4 * k), d, s, v);
      chk($sformatf("R7 first read %0d", k), d, key_val(k));
      chk($sformatf("R9 first read viol %0d", k), 32'(v), 32'h0);
      rd(32'hC200_0000 + 32'(4 * k), d, s, v);
      chk($sformatf("R7 second read %0d", k), d, 32'h0);
    end

    // R5 application registers in loader mode
    wr(32'hFF00_0020, 32'h4001_0000, v); chk("R9 appaddr wr viol", 32'(v), 32'h0);
    wr(32'hFF00_0024, 32'h0000_1234, v);
    rd(32'hFF00_0020, d, s, v); chk("R5 appaddr", d, 32'h4001_0000);
    rd(32'hFF00_0024, d, s, v); chk("R5 appsize", d, 32'h0000_1234);

    // R4 mode switch
    wr(32'hFF00_0010, 32'h0, v);
    chk("R4 zero write keeps loader", 32'(app_mode), 32'h0);
    wr(32'hFF00_0010, 32'h5, v);
    chk("R4 switch sets app mode", 32'(app_mode), 32'h1);
    chk("R9 switch allowed", 32'(v), 32'h0);

    // R6 blocked writes
    wr(32'hFF00_0020, 32'hDEAD_BEEF, v); chk("R6 appaddr wr viol", 32'(v), 32'h1);
    idle(v);                              chk("R9 pulse ends", 32'(v), 32'h0);
    wr(32'hFF00_0024, 32'h0000_9999, v); chk("R6 appsize wr viol", 32'(v), 32'h1);
    rd(32'hFF00_0020, d, s, v); chk("R6 appaddr kept", d, 32'h4001_0000);
    chk("R9 readable reg no viol", 32'(v), 32'h0);
    rd(32'hFF00_0024, d, s, v); chk("R6 appsize kept", d, 32'h0000_1234);
    wr(32'hFF00_0010, 32'h0, v); chk("R6 switch wr viol", 32'(v), 32'h1);
    chk("R4 mode sticky", 32'(app_mode), 32'h1);

    // R8 hidden regions
    rd(32'hC200_0000, d, s, v); chk("R8 secret hidden", d, 32'h0);
    chk("R8 secret viol", 32'(v), 32'h1);
    rd(32'hD000_0000, d, s, v); chk("R8 fwram hidden", d, 32'h0);
    chk("R8 fwram sel", 32'(s), 32'h0);
    chk("R8 fwram viol", 32'(v), 32'h1);
    rd(32'hFF00_0040, d, s, v); chk("R8 auth hidden", d, 32'h0);
    chk("R8 auth viol", 32'(v), 32'h1);
    rd(32'hC000_0000, d, s, v); chk("R2 trng in app mode", d, ext_val(0));
    chk("R9 open core no viol", 32'(v), 32'h0);
    rd(32'hFF00_0000, d, s, v); chk("R3 id0 in app mode", d, 32'h6D74_6131);

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 mode cleared", 32'(app_mode), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(32'hC200_0000, d, s, v); chk("R10 read-once flag cleared", d, key_val(0));
    rd(32'hFF00_0020, d, s, v); chk("R10 appaddr cleared", d, 32'h0);
    rd(32'hFF00_0024, d, s, v); chk("R10 appsize cleared", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule